// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Run-Time Rate Select

This block turns the one-bit output of a second-order sigma-delta modulator into signed 16-bit conversion words. Each modulator bit arrives with a clock enable. Bit value 1 counts as +1 and bit value 0 counts as -1. A cascade of three integrators running at the modulator rate feeds three comb stages running at the output rate. Together they form a sinc-cubed low-pass filter that also decimates.

The oversampling ratio R (bits per output word) is chosen at run time: 32, 64, 128, 256 or 512. Whatever R is chosen, the result is rescaled so that a full-scale input lands at the limits of a 16-bit word. A restart input and any change of the effective ratio both clear the filter. The block then keeps its valid strobe low until the filter has settled again.

Top module: `sdm_sinc3_decimator`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first clock after it, `result` is 0 and `result_valid` is 0.
- R2: Let x[j] be the j-th enabled bit since the last clear, mapped 1 to +1 and 0 to -1, with x = 0 before the clear. The raw word taken at enabled bit n is y = sum over k of h[k]·x[n-3-k], where h is the convolution of three all-ones windows of length R (3R-2 taps).
- R3: The effective ratio code is taken from `osr_ext` and `osr_sel`. When `osr_ext` is 1, R is 512 and `osr_sel` is ignored. Otherwise R = 32·2^`osr_sel` (0 gives 32, 1 gives 64, 2 gives 128, 3 gives 256).
- R4: One raw word is formed for every R enabled bits. Cycles with `mod_en` low change no filter state.
- R5: `result` equals floor(y / 2^(3·log2(R) − 15)) in two's complement, clamped to 32767. A constant all-ones stream gives 32767 and a constant all-zeros stream gives −32768 (16'h8000).
- R6: After reset, restart or a ratio change, the first 3 raw words are not presented. The 4th word and every later word set `result_valid`.
- R7: `result_valid` is a one-cycle pulse. `result` changes only on the edge that raises it and is held at all other times.
- R8: `restart` is synchronous. It clears the filter and the bit counter, the bit presented in that cycle is discarded, and `result` keeps its last value.
- R9: A change of the effective ratio code acts like a restart in the same cycle. Toggling `osr_sel` while `osr_ext` is 1 has no effect.
- R10: A presented word is registered by the same clock edge that accepts the R-th bit of its block. It is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Qualifies `bit_in` as one modulator sample |
| bit_in | input | 1 | Modulator bitstream bit |
| osr_sel | input | 2 | Base ratio select: 32, 64, 128 or 256 |
| osr_ext | input | 1 | Forces ratio 512 |
| restart | input | 1 | Synchronous filter restart |
| result | output | 16 | Signed conversion word |
| result_valid | output | 1 | One-cycle strobe for a new `result` |

## Verification
A word is due on the very edge that takes the R-th enabled bit of a block, so it can be observed half a cycle later. Restarts and ratio changes take effect on the edge where they are presented. The bench model steps once per clock edge on the same inputs the design sees. It builds the weighted sum from its own bit history, and the outputs are compared at every falling edge, so a word that is one cycle early or late is caught. Pulse counts per phase then confirm the settling rule, the ignored select bits and the restart behaviour over whole blocks.

// File: rtl/sinc3_decim_pkg.sv
// Package: shared defaults and the rate-code type for the sinc3 decimator.
// Assumes the base select is two bits wide, so it picks one of four ratios.
package sinc3_decim_pkg;
    localparam int unsigned FILT_ORDER = 3;
    localparam int unsigned LOG_MIN    = 5;
    localparam int unsigned LOG_MAX    = 9;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned SETTLE_N   = 3;

    // Bit 2 marks the extended ratio; bits 1:0 carry the base select.
    typedef logic [2:0] rate_code_t;
    localparam rate_code_t CODE_EXT = 3'b100;
endpackage

// File: rtl/sinc3_rate_ctrl.sv
// Rate control: decodes the ratio code and counts enabled bits per block.
// It raises the decimation event and gates presentation during settling.
// A restart or a change of the effective code clears everything in the same cycle.
// Assumes SETTLE >= 1.
module sinc3_rate_ctrl
    import sinc3_decim_pkg::*;
#(
    parameter int unsigned MIN_LOG = LOG_MIN,
    parameter int unsigned MAX_LOG = LOG_MAX,
    parameter int unsigned SETTLE  = SETTLE_N,
    parameter int unsigned LOG_W   = $clog2(MAX_LOG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       osr_sel,
    input  logic             osr_ext,
    input  logic             restart,
    input  logic             mod_en,
    output logic             clr,
    output logic             dump,
    output logic             fire,
    output logic [LOG_W-1:0] osr_log
);
    localparam int unsigned CNT_W = MAX_LOG;
    localparam int unsigned WC_W  = $clog2(SETTLE + 1);

    rate_code_t       code_now;
    rate_code_t       code_q;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] cnt_last;
    logic [WC_W-1:0]  word_cnt;

    // Effective code: the extended flag overrides the base select.
    assign code_now = osr_ext ? CODE_EXT : {1'b0, osr_sel};
    assign clr      = restart || (code_now != code_q);
    assign osr_log  = code_q[2] ? LOG_W'(MAX_LOG)
                                : LOG_W'(MIN_LOG + int'(code_q[1:0]));
    assign cnt_last = CNT_W'((1 << osr_log) - 1);
    assign dump     = mod_en && !clr && (bit_cnt == cnt_last);
    assign fire     = dump && (word_cnt == WC_W'(SETTLE));

    // Remembers the code in force so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) code_q <= code_now;
    end

    // Counts enabled bits inside the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  bit_cnt <= '0;
        else if (mod_en)    bit_cnt <= dump ? '0 : bit_cnt + 1'b1;
    end

    // Counts discarded words until the filter has settled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                            word_cnt <= '0;
        else if (dump && word_cnt != WC_W'(SETTLE))   word_cnt <= word_cnt + 1'b1;
    end
endmodule

// File: rtl/sinc3_integ_chain.sv
// Integrator cascade at modulator rate, in wrap-around two's complement.
// Stage 0 adds the mapped bit (+1 or -1). Each later stage adds the previous
// stage's registered value, so every stage adds one cycle of delay.
module sinc3_integ_chain #(
    parameter int unsigned ACC_W = 29,
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [ACC_W-1:0] dout
);
    logic [ORDER:0][ACC_W-1:0] acc;

    assign acc[0] = bit_in ? ACC_W'(1) : '1;

    for (genvar s = 0; s < ORDER; s++) begin : g_int
        logic [ACC_W-1:0] sum_q;
        // Accumulates the stage input on each enabled bit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) sum_q <= '0;
            else if (en)       sum_q <= sum_q + acc[s];
        end
        assign acc[s+1] = sum_q;
    end

    assign dout = acc[ORDER];
endmodule

// File: rtl/sinc3_comb_chain.sv
// Comb cascade at the output rate. Each stage subtracts its input value from
// the previous decimation event. Output is combinational from the held state.
module sinc3_comb_chain #(
    parameter int unsigned ACC_W = 29,
    parameter int unsigned ORDER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dump,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    logic [ORDER:0][ACC_W-1:0] tap;

    assign tap[0] = din;

    for (genvar s = 0; s < ORDER; s++) begin : g_comb
        logic [ACC_W-1:0] dly_q;
        // Keeps this stage's input from the previous decimation event.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) dly_q <= '0;
            else if (dump)     dly_q <= tap[s];
        end
        assign tap[s+1] = tap[s] - dly_q;
    end

    assign dout = tap[ORDER];
endmodule

// File: rtl/sinc3_out_scaler.sv
// Output stage: shifts the raw word right arithmetically by ORDER*log2(R)-(OUT_W-1),
// clamps it to OUT_W signed bits and registers it with the strobe.
// Assumes ORDER*MIN_LOG >= OUT_W-1, so the shift is never negative.
module sinc3_out_scaler #(
    parameter int unsigned ACC_W = 29,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned ORDER = 3,
    parameter int unsigned LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LOG_W-1:0] osr_log,
    input  logic [ACC_W-1:0] raw,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);
    localparam int unsigned SH_W = $clog2(ACC_W);
    localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] NEG_MIN = ~POS_MAX;

    logic [SH_W-1:0]         shamt;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] clamped;

    assign shamt   = SH_W'(int'(ORDER) * int'(osr_log) - int'(OUT_W - 1));
    assign shifted = $signed(raw) >>> shamt;

    // Clamps the scaled word into the signed output range.
    always_comb begin
        if (shifted > POS_MAX)      clamped = POS_MAX;
        else if (shifted < NEG_MIN) clamped = NEG_MIN;
        else                        clamped = shifted;
    end

    // Registers a presented word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= fire;
            if (fire) result <= clamped[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sdm_sinc3_decimator.sv
// Top: sinc3 decimator for a one-bit modulator stream with a ratio chosen at run time.
// The integrators run on mod_en, and the combs and output run on decimation events.
// Accumulator width is ORDER*MAX_LOG+2, so +R^ORDER at the largest ratio is representable.
module sdm_sinc3_decimator
    import sinc3_decim_pkg::*;
#(
    parameter int unsigned ORDER   = FILT_ORDER,
    parameter int unsigned MIN_LOG = LOG_MIN,
    parameter int unsigned MAX_LOG = LOG_MAX,
    parameter int unsigned OUT_W   = WORD_W,
    parameter int unsigned SETTLE  = SETTLE_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             bit_in,
    input  logic [1:0]       osr_sel,
    input  logic             osr_ext,
    input  logic             restart,
    output logic [OUT_W-1:0] result,
    output logic             result_valid
);
    localparam int unsigned ACC_W = ORDER * MAX_LOG + 2;
    localparam int unsigned LOG_W = $clog2(MAX_LOG + 1);

    logic             clr;
    logic             dump;
    logic             fire;
    logic [LOG_W-1:0] osr_log;
    logic [ACC_W-1:0] integ_out;
    logic [ACC_W-1:0] comb_out;

    sinc3_rate_ctrl #(
        .MIN_LOG (MIN_LOG),
        .MAX_LOG (MAX_LOG),
        .SETTLE  (SETTLE),
        .LOG_W   (LOG_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .osr_sel (osr_sel),
        .osr_ext (osr_ext),
        .restart (restart),
        .mod_en  (mod_en),
        .clr     (clr),
        .dump    (dump),
        .fire    (fire),
        .osr_log (osr_log)
    );

    sinc3_integ_chain #(
        .ACC_W (ACC_W),
        .ORDER (ORDER)
    ) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .en     (mod_en),
        .bit_in (bit_in),
        .dout   (integ_out)
    );

    sinc3_comb_chain #(
        .ACC_W (ACC_W),
        .ORDER (ORDER)
    ) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .dump  (dump),
        .din   (integ_out),
        .dout  (comb_out)
    );

    sinc3_out_scaler #(
        .ACC_W (ACC_W),
        .OUT_W (OUT_W),
        .ORDER (ORDER),
        .LOG_W (LOG_W)
    ) u_scale (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .osr_log      (osr_log),
        .raw          (comb_out),
        .result       (result),
        .result_valid (result_valid)
    );
endmodule

// File: rtl/sinc3_decim_checker.sv
// Checker: temporal properties of the decimator ports. It keeps its own record
// of the ratio code and counts enabled bits since the last clear.
// Attached to every instance of the top through the bind below.
module sinc3_decim_checker
    import sinc3_decim_pkg::*;
#(
    parameter int unsigned MIN_LOG = LOG_MIN,
    parameter int unsigned MAX_LOG = LOG_MAX,
    parameter int unsigned OUT_W   = WORD_W,
    parameter int unsigned SETTLE  = SETTLE_N
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic [1:0]       osr_sel,
    input logic             osr_ext,
    input logic             restart,
    input logic [OUT_W-1:0] result,
    input logic             result_valid
);
    rate_code_t  ck_code;
    rate_code_t  ck_code_q;
    logic        ck_clr;
    logic [15:0] en_cnt;
    int unsigned need_bits;

    assign ck_code   = osr_ext ? CODE_EXT : {1'b0, osr_sel};
    assign ck_clr    = restart || (ck_code != ck_code_q);
    assign need_bits = (SETTLE + 1) << (ck_code_q[2] ? MAX_LOG : MIN_LOG + int'(ck_code_q[1:0]));

    // Tracks the code in force and the enabled bits seen since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_code_q <= ck_code;
            en_cnt    <= '0;
        end else if (ck_clr) begin
            ck_code_q <= ck_code;
            en_cnt    <= '0;
        end else if (mod_en && en_cnt != 16'hFFFF) begin
            en_cnt <= en_cnt + 16'd1;
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !result_valid);

    a_r9_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_code != ck_code_q) |=> !result_valid);

    a_r6_settle_span: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (32'(en_cnt) >= need_bits));
endmodule

bind sdm_sinc3_decimator sinc3_decim_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_en       (mod_en),
    .osr_sel      (osr_sel),
    .osr_ext      (osr_ext),
    .restart      (restart),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/sdm_sinc3_decimator_tb_top.sv
// Bench: a behavioural model keeps the bit history since the last clear and
// forms each word as a weighted sum. Outputs are compared at every falling edge.
module sdm_sinc3_decimator_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  osr_sel = 2'd0;
    logic        osr_ext = 1'b0;
    logic        restart = 1'b0;
    logic [15:0] result;
    logic        result_valid;

    always #2 clk = ~clk;

    sdm_sinc3_decimator dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_en       (mod_en),
        .bit_in       (bit_in),
        .osr_sel      (osr_sel),
        .osr_ext      (osr_ext),
        .restart      (restart),
        .result       (result),
        .result_valid (result_valid)
    );

    int          checks = 0;
    int          errors = 0;
    string       req = "R1";
    int          pulses = 0;
    logic [15:0] last_res = 16'd0;
    int          cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Model state
    int          xq[$];
    int          m_cnt = 0;
    int          m_words = 0;
    int          m_code = 0;
    logic        exp_valid = 1'b0;
    logic [15:0] exp_res = 16'd0;

    function automatic int code_of(logic ext, logic [1:0] sel);
        return ext ? 4 : int'(sel);
    endfunction

    function automatic int log_of(int c);
        return (c == 4) ? 9 : 5 + c;
    endfunction

    // Number of ways k splits into three parts, each below R.
    function automatic longint tri_w(int r, int k);
        longint c = 0;
        for (int a = 0; a < r; a++) begin
            int s = k - a;
            int lo;
            int hi;
            if (s < 0) break;
            lo = (s - r + 1 > 0) ? s - r + 1 : 0;
            hi = (s < r - 1) ? s : r - 1;
            if (hi >= lo) c += longint'(hi - lo + 1);
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_word(int lg);
        int     r = 1 << lg;
        int     n = xq.size() - 1;
        longint y = 0;
        longint s;
        for (int k = 0; k <= 3 * r - 3; k++) begin
            int idx = n - 3 - k;
            if (idx < 0) break;
            y += tri_w(r, k) * longint'(xq[idx]);
        end
        s = y >>> (3 * lg - 15);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s[15:0];
    endfunction

    // Reference model, one step per rising edge on the applied inputs.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            xq.delete();
            m_cnt = 0;
            m_words = 0;
            m_code = code_of(osr_ext, osr_sel);
            exp_valid = 1'b0;
            exp_res = 16'd0;
        end else begin
            exp_valid = 1'b0;
            if (restart || code_of(osr_ext, osr_sel) != m_code) begin
                xq.delete();
                m_cnt = 0;
                m_words = 0;
                m_code = code_of(osr_ext, osr_sel);
            end else if (mod_en) begin
                xq.push_back(bit_in ? 1 : -1);
                if (m_cnt == (1 << log_of(m_code)) - 1) begin
                    m_cnt = 0;
                    if (m_words == 3) begin
                        exp_valid = 1'b1;
                        exp_res = ref_word(log_of(m_code));
                    end else begin
                        m_words++;
                    end
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // Compares the outputs against the model at every falling edge.
    always @(negedge clk) begin
        checks++;
        if (result_valid !== exp_valid || result !== exp_res) begin
            errors++;
            $display("FAIL %s (R10 word timing) cycle %0d: valid=%0b result=%0d expected valid=%0b result=%0d",
                     req, cycles, result_valid, $signed(result), exp_valid, $signed(exp_res));
        end
        if (result_valid === 1'b1) begin
            pulses++;
            last_res = result;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer than 60000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic expect_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic next_bit(input int dens, output logic b);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        b = (int'(lfsr) % 100) < dens;
    endtask

    task automatic drive(input logic en, input logic b);
        @(posedge clk);
        #1;
        mod_en = en;
        bit_in = b;
        restart = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
    endtask

    // Sends n enabled bits, each followed by gap idle cycles.
    task automatic run(input int n, input int dens, input int gap);
        logic b;
        for (int i = 0; i < n; i++) begin
            next_bit(dens, b);
            drive(1'b1, b);
            for (int g = 0; g < gap; g++) drive(1'b0, b);
        end
    endtask

    task automatic set_cfg(input logic [1:0] sel, input logic ext);
        @(posedge clk);
        #1;
        osr_sel = sel;
        osr_ext = ext;
        mod_en = 1'b0;
        restart = 1'b0;
    endtask

    initial begin
        // R1: reset state
        req = "R1";
        idle(4);
        expect_val("R1 result in reset", int'(result), 0);
        expect_val("R1 valid in reset", int'(result_valid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R2 / R6: ratio 32, random stream, 30 blocks
        req = "R2";
        pulses = 0;
        run(30 * 32, 50, 0);
        idle(2);
        expect_val("R6 words after settling at ratio 32", pulses, 27);

        // R4: gated enable, state frozen on idle cycles
        req = "R4";
        pulses = 0;
        run(8 * 32, 30, 2);
        idle(2);
        expect_val("R4 one word per 32 enabled bits", pulses, 8);

        // R5: clamping at both rails
        req = "R5";
        run(8 * 32, 100, 0);
        idle(2);
        expect_val("R5 all ones clamps to 32767", int'(last_res), 32767);
        run(8 * 32, 0, 0);
        idle(2);
        expect_val("R5 all zeros gives 16'h8000", int'(last_res), 32'h8000);

        // R3: each base ratio after a change
        req = "R3";
        for (int s = 1; s < 4; s++) begin
            set_cfg(2'(s), 1'b0);
            pulses = 0;
            run(6 << (5 + s), 70, 0);
            idle(2);
            expect_val("R3 words presented per base ratio", pulses, 3);
        end
        set_cfg(2'd2, 1'b1);
        pulses = 0;
        run(5 * 512, 100, 0);
        idle(2);
        expect_val("R3 extended ratio 512 word count", pulses, 2);
        expect_val("R5 full scale at ratio 512", int'(last_res), 32767);

        // R9: select toggles ignored while extended ratio is set
        req = "R9";
        pulses = 0;
        for (int i = 0; i < 6 * 512; i++) begin
            logic b;
            next_bit(40, b);
            @(posedge clk);
            #1;
            mod_en = 1'b1;
            bit_in = b;
            osr_sel = 2'(i % 4);
        end
        idle(2);
        expect_val("R9 select ignored under extended ratio", pulses, 6);
        set_cfg(2'd0, 1'b0);
        pulses = 0;
        run(3 * 32, 50, 0);
        idle(2);
        expect_val("R9 ratio change suppresses 3 words", pulses, 0);
        run(32, 50, 0);
        idle(2);
        expect_val("R9 fourth word after change presented", pulses, 1);

        // R8: restart mid block
        req = "R8";
        run(40, 50, 0);
        @(posedge clk);
        #1;
        restart = 1'b1;
        mod_en = 1'b1;
        bit_in = 1'b1;
        pulses = 0;
        run(3 * 32, 50, 0);
        idle(2);
        expect_val("R8 no word within 3 blocks of restart", pulses, 0);
        run(32, 60, 0);
        idle(2);
        expect_val("R8 word after restart settles", pulses, 1);

        idle(4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule